// File: doc/BRIEF.md
# Shadowed PWM Channel

This block produces one pulse-width modulated output. Its time base is a one-cycle enable pulse that arrives at a fixed 1 MHz rate. The pulse is divided by a power of two chosen by a 2-bit code. The divided pulse advances a 16-bit counter that runs over a programmed period. The output is high for the first part of each period, for as many counts as the programmed duty value, and low for the rest.

Software programs the channel through a write-only port with a 2-bit address. The divide code and the duty value only go into shadow registers. Writing the period register asks for an update and raises a pending flag. At the next period boundary all three staged values become live in the same clock, so the waveform never mixes old and new fields.

A period of zero disables the output. The running period still finishes, and the output then stays low. A disabled channel keeps the same update timing as an enabled one: every divided tick counts as a period boundary, so a new setting starts on the next divided tick.

Top module: `pwm_shadow`

## Requirements
- R1: While `rst` is high, the next clock edge clears all registers. After reset `pwm_out` and `pending` are 0 and the channel is disabled, with a live period of 0.
- R2: The live divide code (address 0, bits [1:0]) divides the tick. Code 0 divides by 1, code 1 by 2, code 2 by 4 and code 3 by 8. One counter step takes that many tick pulses.
- R3: When `tick_en` is low, the counter and the output do not change, and a pending update is not applied.
- R4: A period starts at count 0. The output is high while the count is below the live duty value (address 1) and low up to the end of the period. A duty of 0 gives a constant low output. A duty at or above the period gives a constant high output.
- R5: Writes to address 0 or address 1 alone do not change the waveform and do not raise `pending`.
- R6: A write to the period register (address 2) sets `pending` on the next edge. At the end of the running period, the divide code, duty and period all take their staged values on one edge, `pending` clears on that edge, and the new period starts at count 0.
- R7: Committing a period of 0 leaves the running period to finish unchanged. From that boundary on, the output is held low.
- R8: While disabled, every divided tick is a period boundary. A pending update therefore waits for the next tick and is applied on it, and the output then follows the new setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle pulse at the fixed 1 MHz rate |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 = divide code, 1 = duty, 2 = period (requests update), 3 = no effect |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Modulated output |
| pending | output | 1 | High from a period write until that update is applied |

## Verification
The bench measures the high time over whole periods for every divide code. It also covers the two duty extremes, duty 0 and duty at or above the period. A design that counted duty one step off, or that compared the wrong way, would report the wrong high count. The bench writes the divide code and duty without a period write and checks that the waveform keeps its old high count; a design that made these writes live at once would fail here. It stops `tick_en` with an update pending and checks that nothing commits; a design that committed on the clock rather than on the divided tick would apply the update too early. It disables the channel while the output is high and checks that the output stays high until the boundary and then stays low. Finally it re-enables from the disabled state and checks that the update lands on exactly one tick.

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int CW = 16,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_out,
  output logic          pending
);
  localparam int PCW = (1 << PW) - 1;
  localparam logic [1:0] A_DIV = 2'd0, A_DUTY = 2'd1, A_PER = 2'd2;

  logic [PW-1:0]  sh_div, lv_div;
  logic [CW-1:0]  sh_duty, sh_per, lv_duty, lv_per, cnt;
  logic [PCW-1:0] pre;
  logic           pend;

  wire [PCW-1:0] mask   = (PCW'(1) << lv_div) - PCW'(1);
  wire           step   = tick_en && ((pre & mask) == mask);
  wire           last   = (lv_per == '0) || (cnt == lv_per - CW'(1));
  wire           bound  = step && last;
  wire           wr_per = wr_en && (wr_addr == A_PER);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_div  <= '0;
      sh_duty <= '0;
      sh_per  <= '0;
      lv_div  <= '0;
      lv_duty <= '0;
      lv_per  <= '0;
      cnt     <= '0;
      pre     <= '0;
      pend    <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_DIV:   sh_div  <= wr_data[PW-1:0];
          A_DUTY:  sh_duty <= wr_data;
          A_PER:   sh_per  <= wr_data;
          default: ;
        endcase
      end
      if (tick_en) pre <= step ? '0 : pre + PCW'(1);
      if (step) cnt <= last ? '0 : cnt + CW'(1);
      if (bound && pend) begin
        lv_div  <= sh_div;
        lv_duty <= sh_duty;
        lv_per  <= sh_per;
      end
      if (wr_per) pend <= 1'b1;
      else if (bound) pend <= 1'b0;
    end
  end

  assign pwm_out = (lv_per != '0) && (cnt < lv_duty);
  assign pending = pend;
endmodule

module pwm_shadow_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_en,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       pwm_out,
  input logic       pending
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pwm_out && !pending));

  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd2) |=> pending);

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !tick_en) |=> pending);

  // R3
  out_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(pwm_out));

  // R4
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> $past(tick_en));
endmodule

bind pwm_shadow pwm_shadow_chk u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
  .wr_addr(wr_addr), .pwm_out(pwm_out), .pending(pending)
);

// File: tb/sim_pwm_shadow.sv
module sim_pwm_shadow;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out, pending;
  int checks = 0;
  int errors = 0;

  pwm_shadow u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .pending(pending)
  );

  always #10 clk = ~clk;

  localparam int NV = 7;
  localparam int VDIV [NV] = '{0, 1, 2, 3, 0, 2, 1};
  localparam int VDUTY[NV] = '{3, 2, 0, 9, 1, 5, 7};
  localparam int VPER [NV] = '{8, 5, 4, 4, 1, 6, 7};
  localparam int VHIGH[NV] = '{3, 4, 0, 32, 1, 20, 14};
  localparam int VLEN [NV] = '{8, 10, 16, 32, 1, 24, 14};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_commit();
    while (pending) @(negedge clk);
  endtask

  task automatic measure(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      hi += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    bit stay;
    logic o0;
    repeat (3) @(negedge clk);
    chk(!pwm_out && !pending, "R1 reset state", {pwm_out, pending}, 0);
    rst = 1'b0;
    tick_en = 1'b1;

    for (int v = 0; v < NV; v++) begin
      wr(2'd0, 16'(VDIV[v]));
      wr(2'd1, 16'(VDUTY[v]));
      wr(2'd2, 16'(VPER[v]));
      wait_commit();
      chk(pwm_out == (VDUTY[v] > 0), "R4 level at period start", pwm_out, VDUTY[v] > 0);
      measure(2 * VLEN[v], hi);
      chk(hi == 2 * VHIGH[v], "R2 R4 high count over two periods", hi, 2 * VHIGH[v]);
    end

    wr(2'd0, 16'd0); wr(2'd1, 16'd3); wr(2'd2, 16'd8);
    wait_commit();
    wr(2'd1, 16'd6);
    wr(2'd0, 16'd2);
    chk(!pending, "R5 no pending after div/duty writes", pending, 0);
    measure(16, hi);
    chk(hi == 6, "R5 staged writes leave waveform", hi, 6);
    wr(2'd2, 16'd8);
    chk(pending, "R6 pending after period write", pending, 1);
    wait_commit();
    measure(32, hi);
    chk(hi == 24, "R6 all fields switch together", hi, 24);

    tick_en = 1'b0;
    wr(2'd2, 16'd8);
    o0 = pwm_out;
    stay = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (!pending || pwm_out != o0) stay = 1'b0;
      @(negedge clk);
    end
    chk(stay, "R3 no progress without tick", stay, 1);
    tick_en = 1'b1;
    wait_commit();

    wr(2'd0, 16'd0); wr(2'd1, 16'd8); wr(2'd2, 16'd8);
    wait_commit();
    repeat (2) @(negedge clk);
    wr(2'd2, 16'd0);
    chk(pwm_out, "R7 output held through running period", pwm_out, 1);
    stay = 1'b1;
    while (pending) begin
      if (!pwm_out) stay = 1'b0;
      @(negedge clk);
    end
    chk(stay, "R7 no early cut-off", stay, 1);
    measure(20, hi);
    chk(hi == 0, "R7 low after disable", hi, 0);

    tick_en = 1'b0;
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd4);
    repeat (5) @(negedge clk);
    chk(pending && !pwm_out, "R8 waits for tick while disabled", {pending, pwm_out}, 2);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    chk(!pending && pwm_out, "R8 applied on one tick", {pending, pwm_out}, 1);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!pwm_out && !pending, "R1 reset mid-run", {pwm_out, pending}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule